// File: doc/BRIEF.md
# DTMF Tone Pair Generator

This block turns a 4-bit key code into a telephone dual-tone signal given as signed digital samples. It runs from a 3.579545 MHz clock. When the tone-enable input goes from low to high, the block captures the key code. It then runs two dividers, one for the low (row) tone and one for the high (column) tone. Each divider steps its own 28-step sine. The two sine values are added into one signed sample, and the column tone gets a fixed pre-emphasis gain of 11/8, about 2.77 dB.

A mute output stays asserted whenever no tone is playing. A test mode plays only one of the two tones, chosen by a group-select input. The digital-to-analog converter, the output amplifier and the oscillator lie outside this block.

Top module: `dtmf_gen`

## Requirements
- R1: The key code is captured only in the clock cycle where tone_en is high and was low in the previous cycle. Changes to key_code at any other time do not affect the sample.
- R2: In every cycle after a clock edge at which tone_en was low, the output is idle: sample is 0 and mute is 1.
- R3: After each edge at which tone_en is high, mute is 0.
- R4: Row/column decoding of key_code. Codes 1 to 9 give row (code-1)/3 and column (code-1)%3. Code 10 gives row 3, column 1. Code 11 gives row 3, column 0. Code 12 gives row 3, column 2. Codes 13, 14 and 15 give rows 0, 1 and 2, each with column 3. Code 0 gives row 3, column 3.
- R5: The row tones 0..3 (697, 770, 852, 941 Hz) use 184, 166, 150 and 136 clocks per sine step.
- R6: The column tones 0..3 (1209, 1336, 1477, 1633 Hz) use 106, 96, 86 and 78 clocks per sine step. All eight tones come within 0.64% of their nominal frequency.
- R7: Each sine cycle has 28 steps. The value at step p is round(127*sin(2*pi*p/28)), built by quarter-wave symmetry from the magnitudes 0, 28, 55, 79, 99, 114, 124, 127.
- R8: Every burst starts with both phases and both dividers at zero. Counting the capture edge as edge 0, after edge k a tone with divider N is at step floor(k/N) mod 28. So the first sample of every burst is 0.
- R9: In normal mode, sample = 8*row + 11*column. This is a 13-bit signed value whose magnitude never exceeds 2413.
- R10: When solo_en=1, only one tone is output. With solo_high=1 the sample is 11*column; with solo_high=0 it is 8*row.
- R11: rst_n low clears the block at once, without a clock edge, to the idle output (sample 0, mute 1). The reset is released on the clock through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz tone clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | 1 | Rising edge captures code and starts a burst; low stops it |
| key_code | input | 4 | Binary key code |
| solo_en | input | 1 | Single-tone test mode |
| solo_high | input | 1 | In test mode: 1 plays the column tone, 0 the row tone |
| sample | output | 13 | Signed mixed tone sample |
| mute | output | 1 | High while no tone is playing |

## Verification
The bench compares every cycle of each burst against a real-valued sine model, so any error in a divider ratio or a decode entry shows up as a phase slip or a wrong value. The covered cases include:
- all sixteen codes;
- a burst long enough to wrap the slowest tone;
- a one-cycle burst;
- key_code scrambled during bursts and during idle gaps, which a design sampling the code at the wrong time would turn into a tone change;
- solo mode in both groups, which exposes a swapped or unscaled group;
- an asynchronous reset in mid-burst, which a synchronously reset design would not honour until the next edge.

A design that failed to restart its phase on each burst would show a nonzero first sample.

// File: rtl/dtmf_pkg.sv
`timescale 1ns/1ps
package dtmf_pkg;
  localparam int STEPS   = 28;
  localparam int QUARTER = STEPS / 4;
  localparam int PH_W    = $clog2(STEPS);
  localparam int SINE_W  = 8;
  localparam int OUT_W   = SINE_W + 5;
  localparam int DIV_W   = 8;
  localparam int GROUPS  = 2;

  typedef logic signed [SINE_W-1:0] sine_t;
  typedef logic [PH_W-1:0]          phase_t;
  typedef logic [DIV_W-1:0]         div_t;
  typedef logic [1:0]               sel_t;

  function automatic sine_t quarter_mag(input int unsigned r);
    case (r)
      0:       return sine_t'(0);
      1:       return sine_t'(28);
      2:       return sine_t'(55);
      3:       return sine_t'(79);
      4:       return sine_t'(99);
      5:       return sine_t'(114);
      6:       return sine_t'(124);
      default: return sine_t'(127);
    endcase
  endfunction

  function automatic sine_t sine_at(input phase_t ph);
    int unsigned q;
    int unsigned r;
    sine_t mag;
    q = int'(ph) / QUARTER;
    r = int'(ph) % QUARTER;
    mag = (q[0]) ? quarter_mag(QUARTER - r) : quarter_mag(r);
    return (q[1]) ? -mag : mag;
  endfunction
endpackage

// File: rtl/dtmf_decode.sv
`timescale 1ns/1ps
module dtmf_decode
  import dtmf_pkg::*;
#(
  parameter logic [4*DIV_W-1:0] ROW_DIVS = {8'd136, 8'd150, 8'd166, 8'd184},
  parameter logic [4*DIV_W-1:0] COL_DIVS = {8'd78, 8'd86, 8'd96, 8'd106}
) (
  input  logic [3:0] code,
  output div_t       row_div,
  output div_t       col_div
);
  sel_t row, col;

  always_comb begin
    row = 2'd3;
    col = 2'd3;
    case (code)
      4'd1:  begin row = 2'd0; col = 2'd0; end
      4'd2:  begin row = 2'd0; col = 2'd1; end
      4'd3:  begin row = 2'd0; col = 2'd2; end
      4'd4:  begin row = 2'd1; col = 2'd0; end
      4'd5:  begin row = 2'd1; col = 2'd1; end
      4'd6:  begin row = 2'd1; col = 2'd2; end
      4'd7:  begin row = 2'd2; col = 2'd0; end
      4'd8:  begin row = 2'd2; col = 2'd1; end
      4'd9:  begin row = 2'd2; col = 2'd2; end
      4'd10: begin row = 2'd3; col = 2'd1; end
      4'd11: begin row = 2'd3; col = 2'd0; end
      4'd12: begin row = 2'd3; col = 2'd2; end
      4'd13: begin row = 2'd0; col = 2'd3; end
      4'd14: begin row = 2'd1; col = 2'd3; end
      4'd15: begin row = 2'd2; col = 2'd3; end
      default: begin row = 2'd3; col = 2'd3; end
    endcase
  end

  assign row_div = ROW_DIVS[row*DIV_W +: DIV_W];
  assign col_div = COL_DIVS[col*DIV_W +: DIV_W];
endmodule

// File: rtl/dtmf_tone.sv
`timescale 1ns/1ps
module dtmf_tone
  import dtmf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   advance,
  input  div_t   div,
  output phase_t phase,
  output sine_t  wave
);
  div_t   cnt_q, cnt_d;
  phase_t ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (restart) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (advance) begin
      if (cnt_q == div - div_t'(1)) begin
        cnt_d = '0;
        ph_d  = (ph_q == phase_t'(STEPS-1)) ? '0 : ph_q + phase_t'(1);
      end else begin
        cnt_d = cnt_q + div_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (restart || advance) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;
  assign wave  = sine_at(ph_q);
endmodule

// File: rtl/dtmf_mix.sv
`timescale 1ns/1ps
module dtmf_mix
  import dtmf_pkg::*;
(
  input  logic                    run,
  input  logic                    solo_en,
  input  logic                    solo_high,
  input  sine_t                   row_wave,
  input  sine_t                   col_wave,
  output logic signed [OUT_W-1:0] sample
);
  logic signed [OUT_W-1:0] row_x, col_x, row_s, col_s;
  logic use_row, use_col;

  always_comb begin
    row_x   = OUT_W'(row_wave);
    col_x   = OUT_W'(col_wave);
    row_s   = row_x <<< 3;
    col_s   = (col_x <<< 3) + (col_x <<< 1) + col_x;
    use_row = !solo_en || !solo_high;
    use_col = !solo_en || solo_high;
    sample  = '0;
    if (run)
      sample = (use_row ? row_s : '0) + (use_col ? col_s : '0);
  end
endmodule

// File: rtl/dtmf_gen.sv
`timescale 1ns/1ps
module dtmf_gen
  import dtmf_pkg::*;
#(
  parameter logic [4*DIV_W-1:0] ROW_DIVS = {8'd136, 8'd150, 8'd166, 8'd184},
  parameter logic [4*DIV_W-1:0] COL_DIVS = {8'd78, 8'd86, 8'd96, 8'd106}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tone_en,
  input  logic [3:0]              key_code,
  input  logic                    solo_en,
  input  logic                    solo_high,
  output logic signed [OUT_W-1:0] sample,
  output logic                    mute
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       run_q, run_d, rise, advance;
  logic [3:0] code_q, code_d;
  div_t       div_g   [GROUPS];
  phase_t     phase_g [GROUPS];
  sine_t      wave_g  [GROUPS];
  phase_t     lo_phase, hi_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1] & rst_n;

  always_comb begin
    rise    = tone_en && !run_q;
    advance = tone_en && run_q;
    run_d   = tone_en;
    code_d  = rise ? key_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b0;
      code_q <= '0;
    end else begin
      run_q <= run_d;
      if (rise) code_q <= code_d;
    end
  end

  dtmf_decode #(.ROW_DIVS(ROW_DIVS), .COL_DIVS(COL_DIVS)) u_decode (
    .code    (code_q),
    .row_div (div_g[0]),
    .col_div (div_g[1])
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_tone
    dtmf_tone u_tone (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .restart (rise),
      .advance (advance),
      .div     (div_g[g]),
      .phase   (phase_g[g]),
      .wave    (wave_g[g])
    );
  end

  assign lo_phase = phase_g[0];
  assign hi_phase = phase_g[1];

  dtmf_mix u_mix (
    .run       (run_q),
    .solo_en   (solo_en),
    .solo_high (solo_high),
    .row_wave  (wave_g[0]),
    .col_wave  (wave_g[1]),
    .sample    (sample)
  );

  assign mute = !run_q;
endmodule

// File: rtl/dtmf_gen_chk.sv
`timescale 1ns/1ps
module dtmf_gen_chk
  import dtmf_pkg::*;
(
  input logic                    clk,
  input logic                    rst_core_n,
  input logic                    tone_en,
  input logic                    mute,
  input logic signed [OUT_W-1:0] sample,
  input phase_t                  lo_phase,
  input phase_t                  hi_phase,
  input logic [3:0]              code_q,
  input logic                    run_q
);
  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tone_en |=> (mute && sample == '0));

  // R3
  active_mute_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tone_en |=> !mute);

  // R1
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q && tone_en) |=> $stable(code_q));

  // R8
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(mute) |-> (lo_phase == '0 && hi_phase == '0 && sample == '0));

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (int'(lo_phase) < STEPS) && (int'(hi_phase) < STEPS));

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!mute && $past(!mute) && lo_phase != $past(lo_phase)) |->
      (lo_phase == '0 || lo_phase == $past(lo_phase) + phase_t'(1)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sample <= 13'sd2413) && (sample >= -13'sd2413));
endmodule

bind dtmf_gen dtmf_gen_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .tone_en    (tone_en),
  .mute       (mute),
  .sample     (sample),
  .lo_phase   (lo_phase),
  .hi_phase   (hi_phase),
  .code_q     (code_q),
  .run_q      (run_q)
);

// File: tb/dtmf_gen_test.sv
`timescale 1ns/1ps
module dtmf_gen_test;
  localparam real PI = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               tone_en;
  logic [3:0]         key_code;
  logic               solo_en;
  logic               solo_high;
  logic signed [12:0] sample;
  logic               mute;

  int checks = 0;
  int fails  = 0;
  int row_div_tab [4] = '{184, 166, 150, 136};
  int col_div_tab [4] = '{106, 96, 86, 78};

  always #2.5 clk = ~clk;

  dtmf_gen uut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .key_code(key_code),
    .solo_en(solo_en), .solo_high(solo_high), .sample(sample), .mute(mute)
  );

  // R4 decode model
  function automatic void key_rc(input int c, output int r, output int k);
    if (c >= 1 && c <= 9) begin r = (c - 1) / 3; k = (c - 1) % 3; end
    else if (c == 10) begin r = 3; k = 1; end
    else if (c == 11) begin r = 3; k = 0; end
    else if (c == 12) begin r = 3; k = 2; end
    else if (c >= 13) begin r = c - 13; k = 3; end
    else begin r = 3; k = 3; end
  endfunction

  // R7 sine model
  function automatic int wav(input int p);
    return int'(127.0 * $sin(2.0 * PI * p / 28.0));
  endfunction

  // R5 R6 R8 R9 R10 expected sample
  function automatic int expect_s(input int c, input int k, input bit solo, input bit sh);
    int r, cl, lo, hi;
    key_rc(c, r, cl);
    lo = wav((k / row_div_tab[r]) % 28);
    hi = wav((k / col_div_tab[cl]) % 28);
    if (solo) return sh ? 11 * hi : 8 * lo;
    return 8 * lo + 11 * hi;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 idle sample", int'(sample), 0);
      chk("R2 idle mute", int'(mute), 1);
      key_code = 4'($urandom);
    end
  endtask

  task automatic burst(input int c, input int len, input bit solo, input bit sh, input bit scramble);
    @(negedge clk);
    key_code  = 4'(c);
    solo_en   = solo;
    solo_high = sh;
    tone_en   = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (scramble) chk("R1 R4 R8 sample", int'(sample), expect_s(c, k, solo, sh));
      else if (solo) chk("R10 sample", int'(sample), expect_s(c, k, solo, sh));
      else chk("R5/R6/R9 sample", int'(sample), expect_s(c, k, solo, sh));
      chk("R3 mute", int'(mute), 0);
      if (scramble) key_code = 4'($urandom);
    end
    tone_en = 1'b0;
    idle(1 + ($urandom % 4));
  endtask

  initial begin
    void'($urandom(32'd5088));
    rst_n = 1'b0; tone_en = 1'b0; key_code = '0; solo_en = 1'b0; solo_high = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset sample", int'(sample), 0);
    chk("R11 reset mute", int'(mute), 1);
    rst_n = 1'b1;
    idle(4);

    // directed: every code, odd codes with scrambled data (R1)
    for (int c = 0; c < 16; c++)
      burst(c, (c == 1) ? 5300 : 3000, 1'b0, 1'b0, c[0]);
    // R10 single tone both groups
    burst(5, 2000, 1'b1, 1'b1, 1'b0);
    burst(5, 2000, 1'b1, 1'b0, 1'b0);
    burst(13, 1200, 1'b1, 1'b1, 1'b1);
    // one-cycle burst (R8)
    burst(9, 1, 1'b0, 1'b0, 1'b0);
    burst(9, 300, 1'b0, 1'b0, 1'b0);

    // R11 asynchronous reset mid-burst
    @(negedge clk);
    key_code = 4'd6; tone_en = 1'b1;
    repeat (60) @(negedge clk);
    chk("R3 mute before reset", int'(mute), 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R11 async sample", int'(sample), 0);
    chk("R11 async mute", int'(mute), 1);
    tone_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    burst(6, 500, 1'b0, 1'b0, 1'b0);

    // constrained random
    for (int i = 0; i < 12; i++) begin
      int c, len;
      bit solo, sh, scr;
      c    = int'($urandom % 16);
      len  = 1 + int'($urandom % 2500);
      solo = ($urandom % 4) == 0;
      sh   = 1'($urandom);
      scr  = 1'($urandom);
      burst(c, len, solo, sh, scr);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule